// File: doc/BRIEF.md
# Infrared Remote Pulse Receiver

This block takes the demodulated output of an infrared receiver module (high while carrier is present, low otherwise) and turns it into a data word. The line is sampled on a slow tick, and level changes shorter than a programmable length are discarded as noise. An optional leader mark then opens the frame. After that, the space that follows each mark is measured and decoded into one bit. A frame closes when the line stays in one level for a programmed number of ticks, so frames of one format with different lengths are told apart by the reported bit count and not by a fixed length.

Control is a single state machine with six states. `S_IDLE` waits for a rising edge: it moves to `S_LEAD_MARK`, or straight to `S_BIT_MARK` when no leader is configured. `S_LEAD_MARK` goes on to `S_LEAD_SPACE` if the leader mark is long enough and falls back to `S_IDLE` if it is not. `S_LEAD_SPACE` opens the first bit (`S_BIT_MARK`) on the next rising edge. The machine then alternates between `S_BIT_MARK` and `S_BIT_SPACE`, shifting in one bit on each rising edge that ends a space. A level held for the idle limit leads from either bit state to `S_DONE`, and from either leader state back to `S_IDLE`. `S_DONE` lasts one clock and then returns to `S_IDLE`. While the chip sits in low-power hold, a filtered rising edge raises a wake request.

Top module: `ir_pulse_rx`

## Requirements
- R1: After reset, rx_data, rx_bits, rx_overflow, frame_done and wake_req are all 0.
- R2: A change on rx_in is accepted only after the new level has been seen on cfg_filt_units×4 consecutive ticks (0 counts as 1). A pulse shorter than that starts no frame and changes no output.
- R3: cfg_lead_mode encodes 0 = no leader, 1 = half-length leader, 2 or 3 = full-length leader. A leader mark is accepted when its width in ticks is at least cfg_lead_ticks (full) or cfg_lead_ticks>>1 (half). A shorter leader discards the frame without producing frame_done.
- R4: The space after each mark is decoded as 1 when its width in ticks is greater than cfg_bit_thresh and as 0 otherwise. The first bit received goes into rx_data bit 0, and later bits fill upward.
- R5: A frame ends once a bit-phase level has lasted cfg_idle_ticks ticks. frame_done is then high for exactly one clock.
- R6: rx_bits gives the number of bits in the last frame, so frames of one format with different lengths are each reported correctly.
- R7: Bits beyond the 32nd still increase rx_bits but do not change rx_data, and rx_overflow is set. rx_overflow is high only when rx_bits > 32.
- R8: rx_data, rx_bits and rx_overflow keep their values until the next accepted leader (or, with no leader configured, until the first rising edge). They are then cleared.
- R9: While hold_en is high, a filtered rising edge on rx_in sets wake_req. wake_req clears on the clock after hold_en goes low.
- R10: With no leader configured, the first accepted rising edge opens the first bit mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock sampling strobe |
| rx_in | input | 1 | Demodulated receive line, high while carrier is present |
| cfg_lead_mode | input | 2 | Leader format select |
| cfg_filt_units | input | 4 | Noise filter length in units of 4 ticks |
| cfg_lead_ticks | input | 8 | Full leader mark minimum width in ticks |
| cfg_bit_thresh | input | 8 | Space width above which a bit is 1 |
| cfg_idle_ticks | input | 8 | No-change period that closes a frame |
| hold_en | input | 1 | Device is in low-power hold |
| rx_data | output | 32 | Received bits, first bit in bit 0 |
| rx_bits | output | 8 | Bit count of the last frame, saturating |
| rx_overflow | output | 1 | More than 32 bits were received |
| frame_done | output | 1 | One-clock end-of-frame pulse |
| wake_req | output | 1 | Wake request from hold |

## Verification
Some properties are checked on every cycle. The filtered level changes only in a cycle that follows a tick. frame_done never lasts two clocks. rx_overflow implies more than 32 counted bits. The data is stable in every state that neither clears nor shifts. The bit count never drops while bits are being shifted in. wake_req falls after hold is released. Other behaviour can only be shown by the bench scenarios: the decoded values, leader acceptance and rejection at each width, glitch rejection at two filter lengths, and frames of different lengths.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_LEAD_MARK  = 3'd1,
        S_LEAD_SPACE = 3'd2,
        S_BIT_MARK   = 3'd3,
        S_BIT_SPACE  = 3'd4,
        S_DONE       = 3'd5
    } rx_state_e;

    typedef enum logic [1:0] {
        LEAD_NONE = 2'd0,
        LEAD_HALF = 2'd1,
        LEAD_FULL = 2'd2,
        LEAD_FULL_ALT = 2'd3
    } lead_mode_e;

endpackage

// File: rtl/ir_noise_filter.sv
module ir_noise_filter #(
    parameter int TICKS_PER_UNIT = 4,
    parameter int UNIT_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    input  logic [UNIT_W-1:0] units,
    output logic              rise,
    output logic              fall
);
    localparam int FCNT_W = UNIT_W + $clog2(TICKS_PER_UNIT) + 1;

    logic [1:0]        sync_q;
    logic              level_q;
    logic [FCNT_W-1:0] run_q;
    logic [FCNT_W-1:0] eff_units;
    logic [FCNT_W-1:0] limit;

    always_comb begin
        eff_units = (units == '0) ? FCNT_W'(1) : FCNT_W'(units);
        limit     = eff_units * FCNT_W'(TICKS_PER_UNIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            level_q <= 1'b0;
            run_q   <= '0;
            rise    <= 1'b0;
            fall    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rx_in};
            rise   <= 1'b0;
            fall   <= 1'b0;
            if (tick) begin
                if (sync_q[1] != level_q) begin
                    if (run_q == limit - FCNT_W'(1)) begin
                        level_q <= sync_q[1];
                        run_q   <= '0;
                        rise    <= sync_q[1];
                        fall    <= ~sync_q[1];
                    end else begin
                        run_q <= run_q + FCNT_W'(1);
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

    // R2: accepted level only moves on a sampling tick
    p_filt_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> $past(tick));

    // R2: an edge strobe lasts one clock
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall));

endmodule

// File: rtl/ir_width_timer.sv
module ir_width_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] width
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width <= '0;
        end else if (clear) begin
            width <= '0;
        end else if (tick && (width != '1)) begin
            width <= width + CNT_W'(1);
        end
    end

    // R5: the timer never wraps past its saturation value
    p_timer_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(width) == '1 && !$past(clear)) |-> (width == '1));

endmodule

// File: rtl/ir_frame_ctrl.sv
module ir_frame_ctrl
    import ir_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic [CNT_W-1:0]  width,
    input  logic [1:0]        lead_mode,
    input  logic [CNT_W-1:0]  lead_ticks,
    input  logic [CNT_W-1:0]  bit_thresh,
    input  logic [CNT_W-1:0]  idle_ticks,
    output logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  bits,
    output logic              overflow,
    output logic              done
);
    localparam int IDX_W = $clog2(DATA_W);

    rx_state_e  state_q, state_n;
    lead_mode_e mode;
    logic [CNT_W-1:0] lead_min;
    logic timeout, lead_ok, start_clear, shift_en, bit_val;

    always_comb begin
        mode = lead_mode_e'(lead_mode);
        unique case (mode)
            LEAD_HALF: lead_min = lead_ticks >> 1;
            LEAD_NONE: lead_min = '0;
            default:   lead_min = lead_ticks;
        endcase
        timeout     = (width >= idle_ticks);
        lead_ok     = (width >= lead_min);
        start_clear = ((state_q == S_IDLE) && rise && (mode == LEAD_NONE)) ||
                      ((state_q == S_LEAD_MARK) && fall && lead_ok);
        shift_en    = (state_q == S_BIT_SPACE) && rise;
        bit_val     = (width > bit_thresh);
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rise) state_n = (mode == LEAD_NONE) ? S_BIT_MARK : S_LEAD_MARK;
            end
            S_LEAD_MARK: begin
                if (fall)         state_n = lead_ok ? S_LEAD_SPACE : S_IDLE;
                else if (timeout) state_n = S_IDLE;
            end
            S_LEAD_SPACE: begin
                if (rise)         state_n = S_BIT_MARK;
                else if (timeout) state_n = S_IDLE;
            end
            S_BIT_MARK: begin
                if (fall)         state_n = S_BIT_SPACE;
                else if (timeout) state_n = S_DONE;
            end
            S_BIT_SPACE: begin
                if (rise)         state_n = S_BIT_MARK;
                else if (timeout) state_n = S_DONE;
            end
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // outputs and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data     <= '0;
            bits     <= '0;
            overflow <= 1'b0;
        end else if (start_clear) begin
            data     <= '0;
            bits     <= '0;
            overflow <= 1'b0;
        end else if (shift_en) begin
            if (bits < CNT_W'(DATA_W)) data[bits[IDX_W-1:0]] <= bit_val;
            else                       overflow <= 1'b1;
            if (bits != '1) bits <= bits + CNT_W'(1);
        end
    end

    assign done = (state_q == S_DONE);

    // R5: end-of-frame pulse is one clock wide
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: overflow only with more bits than the word holds
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (bits > CNT_W'(DATA_W)));

    // R8: data is held in states that neither clear nor shift
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LEAD_SPACE || state_q == S_BIT_MARK || state_q == S_DONE)
        |=> $stable(data));

    // R6: count never drops while bits are arriving
    p_bits_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BIT_SPACE) |=> (bits >= $past(bits)));

endmodule

// File: rtl/ir_pulse_rx.sv
module ir_pulse_rx #(
    parameter int DATA_W         = 32,
    parameter int CNT_W          = 8,
    parameter int TICKS_PER_UNIT = 4,
    parameter int UNIT_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    input  logic [1:0]        cfg_lead_mode,
    input  logic [UNIT_W-1:0] cfg_filt_units,
    input  logic [CNT_W-1:0]  cfg_lead_ticks,
    input  logic [CNT_W-1:0]  cfg_bit_thresh,
    input  logic [CNT_W-1:0]  cfg_idle_ticks,
    input  logic              hold_en,
    output logic [DATA_W-1:0] rx_data,
    output logic [CNT_W-1:0]  rx_bits,
    output logic              rx_overflow,
    output logic              frame_done,
    output logic              wake_req
);
    logic             f_rise, f_fall;
    logic [CNT_W-1:0] width;

    ir_noise_filter #(
        .TICKS_PER_UNIT(TICKS_PER_UNIT),
        .UNIT_W        (UNIT_W)
    ) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .rx_in(rx_in),
        .units(cfg_filt_units),
        .rise (f_rise),
        .fall (f_fall)
    );

    ir_width_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clear(f_rise | f_fall),
        .width(width)
    );

    ir_frame_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (f_rise),
        .fall      (f_fall),
        .width     (width),
        .lead_mode (cfg_lead_mode),
        .lead_ticks(cfg_lead_ticks),
        .bit_thresh(cfg_bit_thresh),
        .idle_ticks(cfg_idle_ticks),
        .data      (rx_data),
        .bits      (rx_bits),
        .overflow  (rx_overflow),
        .done      (frame_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wake_req <= 1'b0;
        else if (!hold_en) wake_req <= 1'b0;
        else if (f_rise)  wake_req <= 1'b1;
    end

    // R9: leaving hold drops the wake request
    p_wake_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_en |=> !wake_req);

endmodule

// File: tb/sim_ir_pulse_rx.sv
module sim_ir_pulse_rx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b0;
    logic [1:0]  cfg_lead_mode = 2'd2;
    logic [3:0]  cfg_filt_units = 4'd1;
    logic [7:0]  cfg_lead_ticks = 8'd40;
    logic [7:0]  cfg_bit_thresh = 8'd16;
    logic [7:0]  cfg_idle_ticks = 8'd60;
    logic        hold_en = 1'b0;
    logic [31:0] rx_data;
    logic [7:0]  rx_bits;
    logic        rx_overflow, frame_done, wake_req;
    logic [1:0]  tdiv = 2'd0;
    logic        tick;

    int n_checks = 0;
    int n_fail = 0;
    int n_done = 0;
    bit finished = 0;

    typedef struct packed {
        logic [31:0] d;
        logic [7:0]  n;
        logic        o;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd3);

    ir_pulse_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .cfg_lead_mode(cfg_lead_mode), .cfg_filt_units(cfg_filt_units),
        .cfg_lead_ticks(cfg_lead_ticks), .cfg_bit_thresh(cfg_bit_thresh),
        .cfg_idle_ticks(cfg_idle_ticks), .hold_en(hold_en),
        .rx_data(rx_data), .rx_bits(rx_bits), .rx_overflow(rx_overflow),
        .frame_done(frame_done), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model: compare on every clock against queued expectations
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_prev && frame_done) check("R5 pulse width", 64'd2, 64'd1);
            if (frame_done) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    check("R5 unexpected frame_done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R4 rx_data", 64'(rx_data), 64'(e.d));
                    check("R6 rx_bits", 64'(rx_bits), 64'(e.n));
                    check("R7 rx_overflow", 64'(rx_overflow), 64'(e.o));
                end
            end
            if (!frame_done && rx_overflow && rx_bits <= 8'd32)
                check("R7 overflow vs count", 64'(rx_bits), 64'd33);
            done_prev = frame_done;
        end
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    task automatic push_exp(input int nbits, input logic [63:0] pat);
        exp_t e;
        logic [63:0] m;
        m = (nbits >= 32) ? 64'hFFFF_FFFF : ((64'd1 << nbits) - 64'd1);
        e.d = 32'(pat & m);
        e.n = 8'(nbits);
        e.o = (nbits > 32);
        exp_q.push_back(e);
    endtask

    task automatic send_frame(input int lead_w, input int nbits, input logic [63:0] pat);
        if (lead_w > 0) begin
            rx_in = 1'b1; wait_ticks(lead_w);
            rx_in = 1'b0; wait_ticks(20);
        end
        rx_in = 1'b1; wait_ticks(8);
        for (int i = 0; i < nbits; i++) begin
            rx_in = 1'b0; wait_ticks(pat[i] ? 24 : 8);
            rx_in = 1'b1; wait_ticks(8);
        end
        rx_in = 1'b0; wait_ticks(70);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int dc;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 rx_data", 64'(rx_data), 64'd0);
        check("R1 rx_bits", 64'(rx_bits), 64'd0);
        check("R1 flags", {61'd0, rx_overflow, frame_done, wake_req}, 64'd0);
        rst_n = 1'b1;
        wait_ticks(10);

        // R3 full leader, R4 bit order
        push_exp(8, 64'hA5);
        send_frame(40, 8, 64'hA5);
        check("R5 frame completed", 64'(exp_q.size()), 64'd0);

        // R3 half leader at exactly half length
        cfg_lead_mode = 2'd1;
        push_exp(16, 64'h1234);
        send_frame(20, 16, 64'h1234);
        check("R3 half leader frame", 64'(exp_q.size()), 64'd0);

        // R10 no leader
        cfg_lead_mode = 2'd0;
        push_exp(12, 64'hABC);
        send_frame(0, 12, 64'hABC);
        check("R10 no-leader frame", 64'(exp_q.size()), 64'd0);

        // R6 same format, different lengths
        cfg_lead_mode = 2'd3;
        push_exp(5, 64'h16);
        send_frame(40, 5, 64'h16);
        push_exp(7, 64'h55);
        send_frame(40, 7, 64'h55);
        check("R6 variable lengths", 64'(exp_q.size()), 64'd0);

        // R7 overflow
        cfg_lead_mode = 2'd2;
        push_exp(34, 64'h3_DEAD_BEEF);
        send_frame(40, 34, 64'h3_DEAD_BEEF);
        check("R7 overflow frame", 64'(exp_q.size()), 64'd0);

        // R3/R8 short leader rejected, outputs held
        dc = n_done;
        send_frame(30, 6, 64'h3F);
        check("R3 short leader no done", 64'(n_done), 64'(dc));
        check("R8 data held", 64'(rx_data), 64'hDEAD_BEEF);
        check("R8 count held", 64'(rx_bits), 64'd34);
        check("R8 overflow held", 64'(rx_overflow), 64'd1);

        // R2 glitch rejection at two filter lengths
        cfg_lead_mode = 2'd0;
        rx_in = 1'b1; wait_ticks(3); rx_in = 1'b0; wait_ticks(80);
        check("R2 glitch 3 ticks ignored", 64'(n_done), 64'(dc));
        check("R2 data after glitch", 64'(rx_bits), 64'd34);
        cfg_filt_units = 4'd2;
        rx_in = 1'b1; wait_ticks(7); rx_in = 1'b0; wait_ticks(80);
        check("R2 glitch 7 ticks ignored", 64'(n_done), 64'(dc));
        check("R2 data after long glitch", 64'(rx_data), 64'hDEAD_BEEF);
        push_exp(4, 64'h9);
        send_frame(0, 4, 64'h9);
        check("R2 frame with longer filter", 64'(exp_q.size()), 64'd0);
        cfg_filt_units = 4'd1;
        cfg_lead_mode = 2'd2;

        // R9 wake request
        check("R9 no wake outside hold", 64'(wake_req), 64'd0);
        hold_en = 1'b1;
        wait_ticks(2);
        rx_in = 1'b1; wait_ticks(8); rx_in = 1'b0; wait_ticks(4);
        check("R9 wake in hold", 64'(wake_req), 64'd1);
        hold_en = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 wake released", 64'(wake_req), 64'd0);
        wait_ticks(80);
        check("R5 no stray frame", 64'(exp_q.size()), 64'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule